// File: doc/BRIEF.md
# Guarded Sticky Fault Interrupt Flags

This block collects fault and activity indications for a motor-driver system controller and turns them into one interrupt request to the CPU. Five sources are tracked: supply under-voltage, supply over-voltage, over-temperature, over-current and serial line activity. Each source latches a sticky flag when its level-sensitive condition input is high at a clock edge. The flag stays set until software clears it. The over-current indication is built from two sub-flags, one for the supply path and one for the half-bridge path. Those sub-flags are held in their own status register.

Software reaches the block through a small register bus with an address, write data, a write strobe and registered read data. A flag is cleared by writing a 1 to its bit. This clear is refused while the matching condition is still high, so a stray clear can never lose a fault. A separate enable register decides which flags may drive the interrupt request. The request is registered and stays high while any enabled flag remains set.

Top module: `irqf_top`

## Requirements
- R1: After reset every flag, every sub-flag, every enable bit, the read data and `irq` are 0.
- R2: A flag is set at any clock edge where its condition input is high. It stays set after the condition falls until a clear takes effect.
- R3: Writing a 1 to bit 1 (over-voltage), bit 2 (under-voltage), bit 3 (over-temperature) or bit 4 (line activity) of the flag register at offset 0x0 clears that flag. Writing a 0 to a bit leaves the flag unchanged.
- R4: If a flag's condition is high in the same cycle as a clear write to that flag, the flag stays set.
- R5: Bit 0 of the flag register reads as the OR of the two over-current sub-flags. Writes to that bit have no effect.
- R6: The sub-flags sit in the status register at offset 0x8: bit 0 is half-bridge over-current and bit 1 is supply over-current. Each is set by its condition and cleared by writing a 1 to its bit. The clear is refused while its condition is high. Clearing both sub-flags is the only way to clear flag bit 0.
- R7: The enable register at offset 0x4 has these bits: bit 4 line activity, bit 3 over-temperature, bit 2 under-voltage, bit 1 over-voltage, bit 0 over-current. Bits 7 to 5 read as 0 and ignore writes.
- R8: `irq` is high one clock after any flag whose enable bit is 1 is set. It returns low one clock after no enabled flag remains set.
- R9: A flag whose enable bit is 0 never raises `irq`.
- R10: Writes to unmapped offsets change no flag and no enable bit. Reads from unmapped offsets return 0.
- R11: Read data is registered. After a clock edge, `rdata` shows the addressed register as it stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (4) | Register byte offset |
| wdata | input | DATA_W (8) | Write data |
| we | input | 1 | Write strobe, one cycle per write |
| rdata | output | DATA_W (8) | Registered read data |
| cond_lv | input | 1 | Under-voltage condition level |
| cond_hv | input | 1 | Over-voltage condition level |
| cond_ht | input | 1 | Over-temperature condition level |
| cond_lin | input | 1 | Serial line activity condition level |
| cond_oc_sup | input | 1 | Supply over-current condition level |
| cond_oc_br | input | 1 | Half-bridge over-current condition level |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The assertions assume two things about the inputs. First, the condition inputs are already synchronous to `clk` and are stable through each rising edge. Second, `we` is only meaningful together with a settled `addr` and `wdata` in the same cycle. The bench drives every input at the falling edge, so conditions, strobes and data never move near a rising edge. It also pulses `we` for exactly one cycle per write, which matches the single-cycle clear strobe that the flag cells expect.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  // register byte offsets
  localparam int OFS_FLAG = 0;
  localparam int OFS_MASK = 4;
  localparam int OFS_STAT = 8;

  // flag / enable bit positions
  localparam int B_OC  = 0;
  localparam int B_HV  = 1;
  localparam int B_LV  = 2;
  localparam int B_HT  = 3;
  localparam int B_LIN = 4;
  localparam int NSRC  = 5;

  // sub-flag bit positions in the status register
  localparam int S_BR  = 0;
  localparam int S_SUP = 1;
  localparam int NSUB  = 2;
endpackage

// File: rtl/irqf_sticky_flag.sv
module irqf_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic flag
);
  // set has priority over clear; a clear while the condition holds is lost
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (cond) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    cond |=> flag); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !cond) |=> !flag); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R2
endmodule

// File: rtl/irqf_irq_gen.sv
module irqf_irq_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  logic [N-1:0] active;
  assign active = flags & enables;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |active;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (enables == '0) |=> !irq); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && enables[0]) |=> irq); // R8
endmodule

// File: rtl/irqf_top.sv
module irqf_top
  import irqf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  input  logic              cond_lv,
  input  logic              cond_hv,
  input  logic              cond_ht,
  input  logic              cond_lin,
  input  logic              cond_oc_sup,
  input  logic              cond_oc_br,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic wr_flag, wr_mask, wr_stat;
  assign wr_flag = we && (addr == A_FLAG);
  assign wr_mask = we && (addr == A_MASK);
  assign wr_stat = we && (addr == A_STAT);

  // condition vectors in register bit order
  logic [NSRC-1:0] cond_main;
  logic [NSUB-1:0] cond_sub;
  always_comb begin
    cond_main        = '0;
    cond_main[B_HV]  = cond_hv;
    cond_main[B_LV]  = cond_lv;
    cond_main[B_HT]  = cond_ht;
    cond_main[B_LIN] = cond_lin;
    cond_sub         = '0;
    cond_sub[S_BR]   = cond_oc_br;
    cond_sub[S_SUP]  = cond_oc_sup;
  end

  logic [NSRC-1:0] flag_q;
  logic [NSUB-1:0] sub_q;
  logic            oc_any;

  // direct flags: every bit except the derived over-current bit
  for (genvar i = 1; i < NSRC; i++) begin : g_main
    irqf_sticky_flag u_flag (
      .clk (clk),
      .rst (rst),
      .cond(cond_main[i]),
      .clr (wr_flag && wdata[i]),
      .flag(flag_q[i])
    );
  end

  for (genvar j = 0; j < NSUB; j++) begin : g_sub
    irqf_sticky_flag u_sub (
      .clk (clk),
      .rst (rst),
      .cond(cond_sub[j]),
      .clr (wr_stat && wdata[j]),
      .flag(sub_q[j])
    );
  end

  assign oc_any       = |sub_q;
  assign flag_q[B_OC] = oc_any;

  logic [NSRC-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        A_FLAG:  rdata <= DATA_W'(flag_q);
        A_MASK:  rdata <= DATA_W'(mask_q);
        A_STAT:  rdata <= DATA_W'(sub_q);
        default: rdata <= '0;
      endcase
    end
  end

  irqf_irq_gen #(.N(NSRC)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flags  (flag_q),
    .enables(mask_q),
    .irq    (irq)
  );

  AST_OC_CLEAR_PATH: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_any) |-> $past(wr_stat)); // R6
  AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q)); // R10
endmodule

// File: tb/sim_irqf_top.sv
module sim_irqf_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       cond_lv = 0, cond_hv = 0, cond_ht = 0, cond_lin = 0;
  logic       cond_oc_sup = 0, cond_oc_br = 0;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  irqf_top u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .cond_lv(cond_lv), .cond_hv(cond_hv), .cond_ht(cond_ht), .cond_lin(cond_lin),
    .cond_oc_sup(cond_oc_sup), .cond_oc_br(cond_oc_br), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  // rdata after one edge holds the register as it stood before that edge (R11)
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(4'h0, v); chk("R1 flags", v, 8'h00);
    rd(4'h4, v); chk("R1 mask", v, 8'h00);
    rd(4'h8, v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_set_clear();
    logic [7:0] v;
    cond_lv = 1; tick(); cond_lv = 0;
    tick();
    rd(4'h0, v); chk("R2 sticky lv", v, 8'h04);
    wr(4'h0, 8'h00);
    rd(4'h0, v); chk("R3 write0 no effect", v, 8'h04);
    wr(4'h0, 8'h04);
    rd(4'h0, v); chk("R3 write1 clears", v, 8'h00);
  endtask

  task automatic t_guard();
    logic [7:0] v;
    cond_hv = 1; tick();
    wr(4'h0, 8'h02);
    rd(4'h0, v); chk("R4 clear refused", v, 8'h02);
    cond_hv = 0; tick();
    wr(4'h0, 8'h02);
    rd(4'h0, v); chk("R4 clear after drop", v, 8'h00);
  endtask

  task automatic t_overcurrent();
    logic [7:0] v;
    cond_oc_br = 1; tick(); cond_oc_br = 0;
    rd(4'h0, v); chk("R5 oc from bridge", v, 8'h01);
    wr(4'h0, 8'h01);
    rd(4'h0, v); chk("R5 oc read-only", v, 8'h01);
    cond_oc_sup = 1; tick(); cond_oc_sup = 0;
    rd(4'h8, v); chk("R6 both subs", v, 8'h03);
    wr(4'h8, 8'h01);
    rd(4'h8, v); chk("R6 clear bridge", v, 8'h02);
    rd(4'h0, v); chk("R6 oc still set", v, 8'h01);
    cond_oc_sup = 1;
    wr(4'h8, 8'h02);
    rd(4'h8, v); chk("R6 sub clear refused", v, 8'h02);
    cond_oc_sup = 0; tick();
    wr(4'h8, 8'h02);
    rd(4'h0, v); chk("R6 oc cleared", v, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(4'h4, 8'hFF);
    rd(4'h4, v); chk("R7 upper bits zero", v, 8'h1F);
    wr(4'h4, 8'h00);
    rd(4'h4, v); chk("R7 mask cleared", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    cond_ht = 1; tick(); cond_ht = 0;
    tick(); tick();
    chk("R9 masked no irq", {7'd0, irq}, 8'h00);
    wr(4'h4, 8'h08);
    chk("R8 irq not yet", {7'd0, irq}, 8'h00);
    tick();
    chk("R8 irq after enable", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h08);
    chk("R8 irq held one cycle", {7'd0, irq}, 8'h01);
    tick();
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    wr(4'h4, 8'h10);
    cond_lin = 1; tick(); cond_lin = 0;
    chk("R8 irq latency", {7'd0, irq}, 8'h00);
    tick();
    chk("R8 irq lin", {7'd0, irq}, 8'h01);
    rd(4'h0, v); chk("R2 lin flag", v, 8'h10);
    wr(4'h0, 8'h10);
    tick();
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    cond_lv = 1; tick(); cond_lv = 0;
    wr(4'hC, 8'hFF);
    wr(4'h2, 8'hFF);
    rd(4'h4, v); chk("R10 mask untouched", v, 8'h10);
    rd(4'h0, v); chk("R10 flags untouched", v, 8'h04);
    rd(4'hC, v); chk("R10 unmapped reads 0", v, 8'h00);
    wr(4'h0, 8'h04);
    wr(4'h4, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_guard();
    t_overcurrent();
    t_mask();
    t_irq();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule